// File: doc/BRIEF.md
# Capacitor Weight Calibration Sequencer

This block measures how far each capacitor of a binary-weighted switched-capacitor array is from its ideal weight. It does this once, after reset. Each capacitor of the array has a nominal weight equal to the sum of all smaller capacitors plus one spare unit capacitor. The sequencer tests each capacitor against that group. First it charges the capacitor under test to the reference while the group sits at ground and the top plate is held at ground. It then lets the top plate float and exchanges the bottom-plate connections of the two sides. Any charge left on the top plate shows the mismatch. The comparator reports the sign of that charge.

A trim DAC adds a small known charge to the top plate. For each capacitor the sequencer runs a signed successive search on the trim code, taking one comparator decision per step, until the residue is nulled. Capacitors are measured from the smallest upward. Each measurement is therefore relative to a group whose own errors are already known. The sequencer turns each relative result into an absolute weight error by adding the errors already stored for the smaller capacitors. The stored values sit in a small register file that the code reconstruction logic reads. A `cal_done` flag marks the end. The flag stays set, and the switches return to their idle positions, until the next reset.

Top module: `cap_cal_seq`

## Requirements
- R1: While reset is asserted and after it is released, `top_gnd` is 1, `bot_ref` and `unit_ref` are 0, `trim_code` is 0, `cal_done` is 0, and every register-file address reads 0.
- R2: While `start` has not been seen since reset, the switch outputs stay at their idle values and no phase begins.
- R3: In the charge phase for capacitor k, `top_gnd` is 1, `bot_ref` has only bit k set and `unit_ref` is 0. The pattern lasts exactly SETTLE cycles.
- R4: In the float phase for capacitor k, `top_gnd` is 0 and the bottom plates are unchanged from the charge phase, so the top plate is released before any bottom plate moves. The pattern lasts exactly SETTLE cycles.
- R5: In the swap phase for capacitor k, `top_gnd` is 0, `bot_ref` equals (1<<k)-1 and `unit_ref` is 1. The pattern lasts exactly SETTLE cycles, and `cmp_in` is sampled in its last cycle (1 means the trim code is still at or below the null point).
- R6: Capacitors are measured in order from index 0 up to NCAP-1. Each takes exactly TRIM_W charge/float/swap steps, so a run has 3·TRIM_W·NCAP phases.
- R7: `trim_code` is two's complement. The first step of every capacitor presents 0. A trial bit is kept when `cmp_in` is 1 and cleared when it is 0. The result is the largest code for which the comparator answers 1. It is clamped to -2^(TRIM_W-1) if there is no such code, and to 2^(TRIM_W-1)-1 if every code answers 1.
- R8: The value stored for capacitor k is its search result plus the sum of the values stored for all lower indices. It is a signed CORR_W-bit number read combinationally at `rd_addr` = k. Addresses at or above NCAP read 0.
- R9: `cal_done` rises exactly 3·SETTLE·TRIM_W·NCAP cycles after the first charge-phase cycle. It stays at 1, and the switch and trim outputs are idle whenever it is 1.
- R10: After `cal_done`, further `start` pulses have no effect: the switches stay idle and the stored values do not change until reset.
- R11: A `start` pulse while a calibration is running has no effect on the sequence or the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins the single calibration run |
| top_gnd | output | 1 | 1 holds the array top plate at ground, 0 lets it float |
| bot_ref | output | NCAP | Per-capacitor bottom plate: 1 to reference, 0 to ground |
| unit_ref | output | 1 | Bottom plate of the spare unit capacitor: 1 to reference |
| trim_code | output | TRIM_W | Signed trial code for the trim DAC |
| cmp_in | input | 1 | Comparator decision on the top-plate residue |
| rd_addr | input | clog2(NCAP) | Register-file read address |
| rd_data | output | TRIM_W+NCAP+1 | Signed absolute weight error of the addressed capacitor |
| cal_done | output | 1 | All corrections stored |

## Verification
The hardest case to reach is a search result at the edge of the trim range. This covers both a capacitor whose error needs the full negative code and one whose comparator never turns over, and the clamped result then has to be summed into every larger capacitor's stored value. The bench models the array as a comparator that compares the trim code against a per-capacitor null point. It identifies the capacitor under test from the number of bottom plates driven to the reference in the swap phase. Vectors place null points exactly at the two limits and well beyond them. A port monitor rebuilds the expected phase sequence and checks every phase length and capacitor order. It also times the done flag against the first active cycle.

// File: rtl/cap_cal_seq.sv
module cap_cal_seq #(
  parameter int NCAP   = 6,
  parameter int TRIM_W = 5,
  parameter int SETTLE = 3,
  localparam int AW    = $clog2(NCAP),
  localparam int CW    = TRIM_W + NCAP + 1,
  localparam int CNT_W = $clog2(SETTLE + 1),
  localparam int BW    = $clog2(TRIM_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              top_gnd,
  output logic [NCAP-1:0]   bot_ref,
  output logic              unit_ref,
  output logic [TRIM_W-1:0] trim_code,
  input  logic              cmp_in,
  input  logic [AW-1:0]     rd_addr,
  output logic [CW-1:0]     rd_data,
  output logic              cal_done
);

  typedef enum logic [2:0] {S_IDLE, S_CHG, S_FLT, S_SWP, S_DONE} st_t;

  st_t                   st;
  logic [CNT_W-1:0]      cnt;
  logic [AW-1:0]         cap;
  logic [BW-1:0]         bitp;
  logic [TRIM_W-1:0]     trial;
  logic signed [CW-1:0]  acc;
  logic signed [CW-1:0]  mem [NCAP];

  logic                  phase_end;
  logic [TRIM_W-1:0]     trial_fin;
  logic signed [TRIM_W-1:0] meas;
  logic signed [CW-1:0]  cor_new;
  logic [NCAP-1:0]       cap_bit;
  logic                  active;

  localparam logic [TRIM_W-1:0] MID = TRIM_W'(1) << (TRIM_W - 1);

  assign phase_end = (cnt == CNT_W'(SETTLE - 1));
  assign trial_fin = cmp_in ? trial : (trial & ~(TRIM_W'(1) << bitp));
  assign meas      = $signed({~trial_fin[TRIM_W-1], trial_fin[TRIM_W-2:0]});
  assign cor_new   = CW'(meas) + acc;
  assign cap_bit   = NCAP'(1) << cap;
  assign active    = (st == S_CHG) || (st == S_FLT) || (st == S_SWP);

  assign top_gnd   = !((st == S_FLT) || (st == S_SWP));
  assign unit_ref  = (st == S_SWP);
  assign bot_ref   = (st == S_CHG || st == S_FLT) ? cap_bit :
                     (st == S_SWP) ? (cap_bit - NCAP'(1)) : '0;
  assign trim_code = active ? {~trial[TRIM_W-1], trial[TRIM_W-2:0]} : '0;
  assign rd_data   = (int'(rd_addr) < NCAP) ? mem[rd_addr] : '0;
  assign cal_done  = (st == S_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      cap   <= '0;
      bitp  <= '0;
      trial <= '0;
      acc   <= '0;
      for (int i = 0; i < NCAP; i++) mem[i] <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st    <= S_CHG;
          cnt   <= '0;
          cap   <= '0;
          bitp  <= BW'(TRIM_W - 1);
          trial <= MID;
          acc   <= '0;
        end
        S_CHG: begin
          cnt <= phase_end ? '0 : cnt + CNT_W'(1);
          if (phase_end) st <= S_FLT;
        end
        S_FLT: begin
          cnt <= phase_end ? '0 : cnt + CNT_W'(1);
          if (phase_end) st <= S_SWP;
        end
        S_SWP: begin
          cnt <= phase_end ? '0 : cnt + CNT_W'(1);
          if (phase_end) begin
            if (bitp == '0) begin
              mem[cap] <= cor_new;
              acc      <= acc + cor_new;
              if (cap == AW'(NCAP - 1)) begin
                st <= S_DONE;
              end else begin
                cap   <= cap + AW'(1);
                bitp  <= BW'(TRIM_W - 1);
                trial <= MID;
                st    <= S_CHG;
              end
            end else begin
              bitp  <= bitp - BW'(1);
              trial <= trial_fin | (TRIM_W'(1) << (bitp - BW'(1)));
              st    <= S_CHG;
            end
          end
        end
        default: st <= S_DONE;
      endcase
    end
  end

endmodule

module cap_cal_seq_chk #(
  parameter int NCAP   = 6,
  parameter int TRIM_W = 5,
  localparam int AW    = $clog2(NCAP),
  localparam int CW    = TRIM_W + NCAP + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              top_gnd,
  input logic [NCAP-1:0]   bot_ref,
  input logic              unit_ref,
  input logic [TRIM_W-1:0] trim_code,
  input logic [AW-1:0]     rd_addr,
  input logic [CW-1:0]     rd_data,
  input logic              cal_done
);

  a_r3_charge_shape: assert property (@(posedge clk) disable iff (!rst_n)
    top_gnd |-> (!unit_ref && $onehot0(bot_ref)));

  a_r5_swap_floats: assert property (@(posedge clk) disable iff (!rst_n)
    unit_ref |-> !top_gnd);

  a_r4_release_first: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(top_gnd) |-> $stable(bot_ref));

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |-> (top_gnd && bot_ref == '0 && !unit_ref && trim_code == '0));

  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_done |=> cal_done);

  a_r10_store_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_done && $past(cal_done) && $stable(rd_addr)) |-> $stable(rd_data));

endmodule

bind cap_cal_seq cap_cal_seq_chk #(.NCAP(NCAP), .TRIM_W(TRIM_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .top_gnd(top_gnd), .bot_ref(bot_ref),
  .unit_ref(unit_ref), .trim_code(trim_code), .rd_addr(rd_addr),
  .rd_data(rd_data), .cal_done(cal_done)
);

// File: tb/cap_cal_seq_tb_top.sv
module cap_cal_seq_tb_top;
  localparam int CLK_P  = 10;
  localparam int NCAP   = 6;
  localparam int TW     = 5;
  localparam int ST     = 3;
  localparam int AW     = $clog2(NCAP);
  localparam int CW     = TW + NCAP + 1;
  localparam int T_RUN  = 3 * ST * TW * NCAP;
  localparam int NVEC   = 4;
  localparam int SW     = NCAP + 2;
  localparam logic [SW-1:0] IDLE_SIG = {1'b1, 1'b0, {NCAP{1'b0}}};

  localparam int MTAB [NVEC][NCAP] = '{
    '{0, 0, 0, 0, 0, 0},
    '{3, -2, 5, -7, 1, -1},
    '{15, -16, 15, -16, 0, 0},
    '{20, -30, 7, -9, 40, -2}
  };

  logic clk = 0, rst_n = 0, start = 0, cmp_in;
  logic top_gnd, unit_ref, cal_done;
  logic [NCAP-1:0] bot_ref;
  logic [TW-1:0] trim_code;
  logic [AW-1:0] rd_addr = '0;
  logic [CW-1:0] rd_data;

  int checks = 0, errors = 0;
  int cur_m [NCAP];

  always #(CLK_P/2) clk = ~clk;

  cap_cal_seq #(.NCAP(NCAP), .TRIM_W(TW), .SETTLE(ST)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .top_gnd(top_gnd),
    .bot_ref(bot_ref), .unit_ref(unit_ref), .trim_code(trim_code),
    .cmp_in(cmp_in), .rd_addr(rd_addr), .rd_data(rd_data), .cal_done(cal_done)
  );

  always_comb begin
    int k;
    k = $countones(bot_ref);
    cmp_in = (k < NCAP) ? (int'($signed(trim_code)) <= cur_m[k]) : 1'b0;
  end

  // port monitor
  logic [SW-1:0] prev_sig;
  int run_len, ek, eph, estep, bad_seq, bad_len, nph, cyc, first_act, done_cyc;
  bit mon_en = 0;

  function automatic logic [SW-1:0] exp_sig(int k, int ph);
    logic [NCAP-1:0] b;
    b = NCAP'(1) << k;
    case (ph)
      0: return {1'b1, 1'b0, b};
      1: return {1'b0, 1'b0, b};
      default: return {1'b0, 1'b1, b - NCAP'(1)};
    endcase
  endfunction

  task automatic mon_clear();
    prev_sig = IDLE_SIG; run_len = 0; ek = 0; eph = 0; estep = 0;
    bad_seq = 0; bad_len = 0; nph = 0; cyc = 0; first_act = -1; done_cyc = -1;
  endtask

  always @(negedge clk) if (mon_en) begin
    logic [SW-1:0] sig;
    sig = {top_gnd, unit_ref, bot_ref};
    cyc++;
    if (sig != prev_sig) begin
      if (prev_sig != IDLE_SIG && run_len != ST) bad_len++;
      if (sig != IDLE_SIG) begin
        if (first_act < 0) first_act = cyc;
        if (ek >= NCAP || sig != exp_sig(ek, eph)) bad_seq++;
        if (eph == 0 && estep == 0 && trim_code != '0) bad_seq++;
        nph++;
        if (eph == 2) begin
          eph = 0; estep++;
          if (estep == TW) begin estep = 0; ek++; end
        end else eph++;
      end
      run_len = 1;
      prev_sig = sig;
    end else run_len++;
    if (cal_done && done_cyc < 0) done_cyc = cyc;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; start = 0;
    repeat (3) @(negedge clk);
    chk("R1 top_gnd in reset", int'(top_gnd), 1);
    chk("R1 done in reset", int'(cal_done), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle switches", int'({unit_ref, bot_ref}), 0);
    chk("R1 idle trim", int'(trim_code), 0);
    for (int a = 0; a < (1 << AW); a++) begin
      rd_addr = AW'(a); #1;
      chk("R1 cleared store", int'($signed(rd_data)), 0);
    end
  endtask

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  function automatic int clampv(int v);
    int lo = -(1 << (TW - 1));
    int hi = (1 << (TW - 1)) - 1;
    return (v < lo) ? lo : (v > hi) ? hi : v;
  endfunction

  task automatic run_vec(int v);
    int exp_cor [NCAP];
    int sum;
    int saved [NCAP];
    for (int k = 0; k < NCAP; k++) cur_m[k] = MTAB[v][k];
    do_reset();
    mon_clear(); mon_en = 1;
    repeat (10) @(negedge clk);
    chk("R2 no phase before start", nph, 0);
    pulse_start();
    if (v == 1) begin
      repeat (40) @(negedge clk);
      pulse_start();   // R11: ignored mid-run
    end
    for (int i = 0; i < 2 * T_RUN && !cal_done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R6 phase count", nph, 3 * TW * NCAP);
    chk("R3 R4 R5 R6 R7 phase pattern/order", bad_seq, 0);
    chk("R3 R4 R5 settle length", bad_len, 0);
    chk("R9 done latency", done_cyc - first_act, T_RUN);
    chk("R9 done high", int'(cal_done), 1);
    chk("R9 idle after done", int'({top_gnd, unit_ref, bot_ref, trim_code}),
        int'({1'b1, 1'b0, {NCAP{1'b0}}, {TW{1'b0}}}));
    sum = 0;
    for (int k = 0; k < NCAP; k++) begin
      exp_cor[k] = clampv(MTAB[v][k]) + sum;
      sum += exp_cor[k];
      rd_addr = AW'(k); #1;
      saved[k] = int'($signed(rd_data));
      chk($sformatf("R7 R8 v%0d cap%0d correction", v, k), saved[k], exp_cor[k]);
    end
    for (int a = NCAP; a < (1 << AW); a++) begin
      rd_addr = AW'(a); #1;
      chk("R8 out-of-range address", int'($signed(rd_data)), 0);
    end
    if (v == 2) begin
      int nph0 = nph;
      pulse_start();
      repeat (100) @(negedge clk);
      chk("R10 no rerun", nph, nph0);
      chk("R10 done held", int'(cal_done), 1);
      for (int k = 0; k < NCAP; k++) begin
        rd_addr = AW'(k); #1;
        chk("R10 store unchanged", int'($signed(rd_data)), saved[k]);
      end
    end
    mon_en = 0;
  endtask

  initial begin
    for (int k = 0; k < NCAP; k++) cur_m[k] = 0;
    mon_clear();
    for (int v = 0; v < NVEC; v++) run_vec(v);
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end
endmodule